// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number. It walks a two-level page map kept in a word-addressed memory. The upper half of the virtual page number picks one word in a page directory. The directory is a single page whose location is held in a base register. That directory word names the physical page holding the second-level map for that slice of the address space. The lower half of the virtual page number then picks the final entry inside that page. Only the second-level pages that are in use need to be resident in memory.

A client places a virtual page number on a valid/ready request port. The walker then makes at most two memory reads, strictly one after the other, with one read in flight at a time. It answers on a valid/ready response port with either a physical page number or a fault. While a walk is active, new requests and writes to the base register are held off, so every walk sees one consistent directory base.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the directory base is 0, so the first walk reads its directory entry from page 0.
- R2: The first read of a walk goes to word address `{base, vpn[19:10]}`. The base is the upper 20 bits of the 30-bit word address, and the directory index is the low 10 bits.
- R3: The second read goes to word address `{dir_entry[19:0], vpn[9:0]}`.
- R4: In both levels, entry bit 31 is the present flag and bits 19:0 are the page number. Bits 30:20 have no effect on the result.
- R5: If the directory entry has bit 31 clear, the walk makes exactly one read and responds with `rsp_fault`=1 and `rsp_ppn`=0.
- R6: If the leaf entry has bit 31 clear, the walk makes exactly two reads and responds with `rsp_fault`=1 and `rsp_ppn`=0.
- R7: If both entries are present, the walk makes exactly two reads and responds with `rsp_fault`=0 and `rsp_ppn` equal to the leaf entry's bits 19:0.
- R8: At most one memory read is outstanding. After a read is accepted, `mem_req_valid` stays low until that read's data has returned.
- R9: `req_ready` is high only while no walk is in progress. A request is accepted only after the previous response handshake. `rsp_valid`, `rsp_fault` and `rsp_ppn` hold steady until `rsp_ready` is seen.
- R10: A pulse on `base_load` replaces the directory base only in a cycle where `req_ready` is 1. In any other cycle it has no effect.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with an unchanged `mem_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Client accepts the result |
| rsp_fault | output | 1 | A level of the walk was not present |
| rsp_ppn | output | 20 | Translated physical page number (0 on fault) |
| base_load | input | 1 | Strobe to write the directory base |
| base_ppn_in | input | 20 | New directory base page |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 30 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The bench builds the walker with its default sizes: a 20-bit virtual page number, a 20-bit physical page number and 32-bit entries with the present flag at bit 31. With these sizes the exact word addresses of both reads can be predicted and checked bit for bit. Junk in the unused entry bits 30:20 can be placed where it must be ignored. The directory, the second-level pages and unmapped holes can all be scattered over a sparse memory. Random memory stalls and random response back-pressure exercise the hold rules on both handshakes. A base-register write made in the middle of a walk tests whether that write is blocked.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int unsigned PTW_VPN_W       = 20;
    localparam int unsigned PTW_PPN_W       = 20;
    localparam int unsigned PTW_WORD_W      = 32;
    localparam int unsigned PTW_PRESENT_BIT = 31;

    typedef enum logic [2:0] {
        WK_IDLE    = 3'd0,
        WK_DIR_RD  = 3'd1,
        WK_DIR_WT  = 3'd2,
        WK_LEAF_RD = 3'd3,
        WK_LEAF_WT = 3'd4,
        WK_RESP    = 3'd5
    } walk_state_e;

    typedef enum logic {
        SEL_DIR  = 1'b0,
        SEL_LEAF = 1'b1
    } rd_sel_e;

    function automatic logic is_read_state(walk_state_e s);
        return (s == WK_DIR_RD) || (s == WK_LEAF_RD);
    endfunction

    function automatic rd_sel_e level_of(walk_state_e s);
        return ((s == WK_LEAF_RD) || (s == WK_LEAF_WT)) ? SEL_LEAF : SEL_DIR;
    endfunction

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg
    import pt_walker_pkg::*;
#(
    parameter int unsigned PPN_W = PTW_PPN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [PPN_W-1:0] load_ppn,
    input  logic             idle,
    output logic [PPN_W-1:0] base_ppn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_ppn <= '0;
        end else if (load_en && idle) begin
            base_ppn <= load_ppn;
        end
    end

endmodule

// File: rtl/pt_addr_mux.sv
module pt_addr_mux
    import pt_walker_pkg::*;
#(
    parameter int unsigned VPN_W  = PTW_VPN_W,
    parameter int unsigned PPN_W  = PTW_PPN_W,
    parameter int unsigned IDX_W  = VPN_W / 2,
    parameter int unsigned ADDR_W = PPN_W + IDX_W
) (
    input  rd_sel_e           sel,
    input  logic [PPN_W-1:0]  base_ppn,
    input  logic [PPN_W-1:0]  tbl_ppn,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] addr
);

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] leaf_idx;

    assign dir_idx  = vpn[VPN_W-1 -: IDX_W];
    assign leaf_idx = vpn[IDX_W-1:0];

    always_comb begin
        if (sel == SEL_LEAF) begin
            addr = {tbl_ppn, leaf_idx};
        end else begin
            addr = {base_ppn, dir_idx};
        end
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int unsigned VPN_W       = PTW_VPN_W,
    parameter int unsigned PPN_W       = PTW_PPN_W,
    parameter int unsigned WORD_W      = PTW_WORD_W,
    parameter int unsigned PRESENT_BIT = PTW_PRESENT_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              req_ready,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output rd_sel_e           rd_sel,
    output logic [VPN_W-1:0]  vpn_q,
    output logic [PPN_W-1:0]  tbl_ppn_q
);

    walk_state_e      state_q;
    logic             fault_q;
    logic [PPN_W-1:0] ppn_q;
    logic             ent_present;
    logic [PPN_W-1:0] ent_ppn;
    logic             ent_unused;

    assign ent_present = mem_rsp_data[PRESENT_BIT];
    assign ent_ppn     = mem_rsp_data[PPN_W-1:0];
    assign ent_unused  = ^mem_rsp_data;

    assign req_ready     = (state_q == WK_IDLE);
    assign rsp_valid     = (state_q == WK_RESP);
    assign mem_req_valid = is_read_state(state_q);
    assign rd_sel        = level_of(state_q);
    assign rsp_fault     = fault_q;
    assign rsp_ppn       = ppn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WK_IDLE;
            vpn_q     <= '0;
            tbl_ppn_q <= '0;
            fault_q   <= 1'b0;
            ppn_q     <= '0;
        end else begin
            case (state_q)
                WK_IDLE: begin
                    if (req_valid) begin
                        vpn_q   <= req_vpn;
                        state_q <= WK_DIR_RD;
                    end
                end
                WK_DIR_RD: begin
                    if (mem_req_ready) begin
                        state_q <= WK_DIR_WT;
                    end
                end
                WK_DIR_WT: begin
                    if (mem_rsp_valid) begin
                        if (ent_present) begin
                            tbl_ppn_q <= ent_ppn;
                            state_q   <= WK_LEAF_RD;
                        end else begin
                            fault_q <= 1'b1;
                            ppn_q   <= '0;
                            state_q <= WK_RESP;
                        end
                    end
                end
                WK_LEAF_RD: begin
                    if (mem_req_ready) begin
                        state_q <= WK_LEAF_WT;
                    end
                end
                WK_LEAF_WT: begin
                    if (mem_rsp_valid) begin
                        fault_q <= ~ent_present;
                        ppn_q   <= ent_present ? ent_ppn : '0;
                        state_q <= WK_RESP;
                    end
                end
                WK_RESP: begin
                    if (rsp_ready) begin
                        state_q <= WK_IDLE;
                    end
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ppn) && $stable(rsp_fault));

    // R5
    fault_ppn_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_ppn == '0);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned VPN_W       = PTW_VPN_W,
    parameter int unsigned PPN_W       = PTW_PPN_W,
    parameter int unsigned WORD_W      = PTW_WORD_W,
    parameter int unsigned PRESENT_BIT = PTW_PRESENT_BIT,
    localparam int unsigned IDX_W      = VPN_W / 2,
    localparam int unsigned ADDR_W     = PPN_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [PPN_W-1:0]  rsp_ppn,
    input  logic              base_load,
    input  logic [PPN_W-1:0]  base_ppn_in,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);

    logic [PPN_W-1:0] base_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [VPN_W-1:0] vpn_q;
    rd_sel_e          rd_sel;

    pt_base_reg #(.PPN_W(PPN_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .load_en  (base_load),
        .load_ppn (base_ppn_in),
        .idle     (req_ready),
        .base_ppn (base_q)
    );

    pt_walk_ctrl #(
        .VPN_W       (VPN_W),
        .PPN_W       (PPN_W),
        .WORD_W      (WORD_W),
        .PRESENT_BIT (PRESENT_BIT)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vpn       (req_vpn),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_fault     (rsp_fault),
        .rsp_ppn       (rsp_ppn),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rd_sel        (rd_sel),
        .vpn_q         (vpn_q),
        .tbl_ppn_q     (tbl_ppn_q)
    );

    pt_addr_mux #(
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .sel      (rd_sel),
        .base_ppn (base_q),
        .tbl_ppn  (tbl_ppn_q),
        .vpn      (vpn_q),
        .addr     (mem_req_addr)
    );

    // R11
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R10
    base_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(base_q));

    // R9
    accept_starts_walk_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> mem_req_valid && !req_ready && !rsp_valid);

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    localparam int VPN_W  = 20;
    localparam int PPN_W  = 20;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 30;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn;
    logic              rsp_valid;
    logic              rsp_ready;
    logic              rsp_fault;
    logic [PPN_W-1:0]  rsp_ppn;
    logic              base_load;
    logic [PPN_W-1:0]  base_ppn_in;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid;
    logic [WORD_W-1:0] mem_rsp_data;

    pt_walker u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vpn       (req_vpn),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_fault     (rsp_fault),
        .rsp_ppn       (rsp_ppn),
        .base_load     (base_load),
        .base_ppn_in   (base_ppn_in),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    always #4 clk = ~clk;

    logic [31:0] pte_mem [int unsigned];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          rd_count = 0;
    logic [29:0] rd_log [0:3];
    logic        mem_busy = 1'b0;
    bit          run_mem  = 1'b0;

    function automatic logic [31:0] mem_rd(int unsigned a);
        if (pte_mem.exists(a)) return pte_mem[a];
        return 32'h0;
    endfunction

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: one read at a time, random stalls and latency
    initial begin : mem_model
        int          wait_cnt;
        int unsigned pend;
        bit          stalled;
        logic [29:0] stall_addr;
        wait_cnt = 0;
        pend = 0;
        stalled = 1'b0;
        stall_addr = '0;
        forever begin
            @(negedge clk);
            if (run_mem) begin
                if (stalled) begin
                    // R11: stalled request stays put
                    check_eq("R11", "held request", {mem_req_valid, mem_req_addr},
                             {1'b1, stall_addr});
                end
                if (mem_busy) begin
                    // R8: no new request while a read is in flight
                    check_eq("R8", "request while busy", mem_req_valid, 0);
                end
            end
            mem_rsp_valid = 1'b0;
            if (mem_busy) begin
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_rd(pend);
                    mem_busy      = 1'b0;
                end else begin
                    wait_cnt--;
                end
            end
            mem_req_ready = !mem_busy && (($urandom % 4) != 0);
            stalled = 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_busy = 1'b1;
                pend     = int'(mem_req_addr);
                wait_cnt = $urandom % 3;
                if (rd_count < 4) rd_log[rd_count] = mem_req_addr;
                rd_count++;
            end else if (mem_req_valid) begin
                stalled    = 1'b1;
                stall_addr = mem_req_addr;
            end
        end
    end

    task automatic walk(input logic [19:0] vpn, input logic [19:0] base, input bit poke,
                        input string tag);
        logic [31:0] d;
        logic [31:0] l;
        int unsigned a0;
        int unsigned a1;
        bit          e_fault;
        logic [19:0] e_ppn;
        int          e_reads;
        string       rq;
        int          g;
        logic        s_fault;
        logic [19:0] s_ppn;
        a0 = {2'b00, base, vpn[19:10]};
        d  = mem_rd(a0);
        a1 = {2'b00, d[19:0], vpn[9:0]};
        l  = 32'h0;
        if (!d[31]) begin
            e_fault = 1'b1; e_ppn = '0; e_reads = 1; rq = "R5";
        end else begin
            l = mem_rd(a1);
            e_reads = 2;
            if (!l[31]) begin
                e_fault = 1'b1; e_ppn = '0; rq = "R6";
            end else begin
                e_fault = 1'b0; e_ppn = l[19:0]; rq = "R7";
            end
        end
        rd_count = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = vpn;
        g = 0;
        while (!req_ready && g < 200) begin @(negedge clk); g++; end
        @(negedge clk);
        req_valid = 1'b0;
        req_vpn   = 20'($urandom);
        check_eq("R9", {tag, " ready during walk"}, req_ready, 0);
        if (poke) begin
            base_load   = 1'b1;
            base_ppn_in = ~base;
            @(negedge clk);
            base_load   = 1'b0;
        end
        g = 0;
        while (!rsp_valid && g < 500) begin @(negedge clk); g++; end
        if (g >= 500) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s %s: actual timeout expected response", rq, tag);
            return;
        end
        check_eq(rq, {tag, " fault"}, rsp_fault, e_fault);
        check_eq(rq, {tag, " ppn"}, rsp_ppn, e_ppn);
        check_eq(rq, {tag, " read count"}, rd_count, e_reads);
        check_eq("R2", {tag, " dir address"}, rd_log[0], a0);
        if (e_reads == 2) check_eq("R3", {tag, " leaf address"}, rd_log[1], a1);
        s_fault = rsp_fault;
        s_ppn   = rsp_ppn;
        repeat ($urandom % 3) begin
            @(negedge clk);
            check_eq("R9", {tag, " held response"}, {rsp_valid, rsp_fault, rsp_ppn},
                     {1'b1, s_fault, s_ppn});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check_eq("R9", {tag, " back to idle"}, {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin : main
        logic [19:0] base_a;
        void'($urandom(32'd2024));
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; rsp_ready = 1'b0;
        base_load = 1'b0; base_ppn_in = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        base_a = 20'h00123;

        // tables reached through base 0
        pte_mem[{2'b00, 20'h00000, 10'd5}] = 32'h8000_0400;
        pte_mem[{2'b00, 20'h00400, 10'd7}] = 32'h8005_5AA1;
        // tables reached through base_a
        for (int h = 0; h < 8; h++) begin
            logic [31:0] e;
            e = {1'b0, 11'($urandom), 20'h00800 + 20'(h)};
            e[31] = (h < 6);
            pte_mem[{2'b00, base_a, 10'(h)}] = e;
            for (int lo = 0; lo < 16; lo++) begin
                logic [31:0] le;
                le = $urandom;
                le[31] = ((lo % 4) != 3);
                pte_mem[{2'b00, 20'h00800 + 20'(h), 10'(lo)}] = le;
            end
        end
        // R4 directed entries: junk in bits 30:20
        pte_mem[{2'b00, base_a, 10'd9}]    = 32'h7FFF_FFFF;
        pte_mem[{2'b00, base_a, 10'd10}]   = 32'hFFF0_0900;
        pte_mem[{2'b00, 20'h00900, 10'd1}] = 32'hFFFA_BCDE;
        pte_mem[{2'b00, 20'h00900, 10'd2}] = 32'h7FF1_2345;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_mem = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "reset outputs", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
        // R1: base is zero after reset
        walk({10'd5, 10'd7}, 20'h00000, 1'b0, "R1 base zero");

        // R10: load at idle takes effect
        @(negedge clk);
        base_load = 1'b1; base_ppn_in = base_a;
        @(negedge clk);
        base_load = 1'b0;
        walk({10'd0, 10'd1}, base_a, 1'b0, "R10 load idle");
        // R10: load during walk ignored, then still ignored on next walk
        walk({10'd1, 10'd2}, base_a, 1'b1, "R10 load busy");
        walk({10'd2, 10'd0}, base_a, 1'b0, "R10 after busy");

        // R4 directed
        walk({10'd9, 10'd1}, base_a, 1'b0, "R4 dir junk absent");
        walk({10'd10, 10'd1}, base_a, 1'b0, "R4 junk present");
        walk({10'd10, 10'd2}, base_a, 1'b0, "R4 leaf junk absent");
        // R5 directory miss, R6 leaf miss, R7 hit
        walk({10'd7, 10'd0}, base_a, 1'b0, "R5 dir absent");
        walk({10'd0, 10'd3}, base_a, 1'b0, "R6 leaf absent");
        walk({10'd3, 10'd4}, base_a, 1'b0, "R7 hit");

        // constrained random
        for (int i = 0; i < 60; i++) begin
            logic [9:0] hi;
            logic [9:0] lo;
            hi = (($urandom % 5) == 0) ? 10'($urandom) : 10'($urandom % 8);
            lo = 10'($urandom % 24);
            walk({hi, lo}, base_a, 1'($urandom % 2), "random");
        end

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule